// File: doc/BRIEF.md
# Cache Cluster Power-Up Sequencer

This block is a hardware state machine that brings a shared second-level cache cluster out of its unpowered state. A one-cycle start request begins the work. If the cluster's head-switch status input already reports power, the block does nothing and completes in the next cycle. Otherwise it steps through a fixed series of writes on three output words, holding each stage for a timed settling interval.

The three output words are a 32-bit power control word for the cache, a single debug-preset override bit, and a two-bit clock branch word. The clock branch word has a clock enable in bit 0 and a hardware-control handover bit in bit 1. Settling waits of 2 µs and 54 µs come from one down-counter. The counter's cycles-per-microsecond figure is a synthesis parameter. A one-cycle done pulse marks the end of either path, and a skipped flag that pulses with it tells the two paths apart.

Top module: `l2_pwrup_seq`

## Requirements
- R1: While reset is held and after its release, all three output words are zero, and busy, done and skipped are low.
- R2: A start sampled while idle with the status input high changes none of the output words. It raises done and skipped together for exactly one cycle, one cycle after the start edge, and busy stays low.
- R3: A start sampled while idle with the status input low writes the control word 0x0010D700 one cycle later. That value sets bits 8 (head-switch clamp), 9 (head-switch enable), 10 (head-switch reset), 12 (system reset), 14 (SCU array clamp) and 15 (cache array clamp), with a switch count of 16 in bits [23:16]. The same write sets the override bit, clears the clock word and raises busy.
- R4: After the first short wait, bits 14 and 15 clear (0x00101700). One cycle later bits 0 and 1, the array head switches, set (0x00101703).
- R5: After the second short wait, clock word bit 0 sets. One cycle later control bit 8 clears (0x00101603).
- R6: After the third short wait, the override bit clears. One cycle later bits 10 and 12 clear together (0x00100203).
- R7: After the long wait, bit 28 (power-supply on) sets (0x10100203). One cycle later clock word bit 1 sets, done pulses for one cycle and skipped stays low.
- R8: Each short wait holds the outputs for exactly 2×CYC_PER_US cycles and the long wait for exactly 54×CYC_PER_US cycles. Bit 11 (sleep) is never set.
- R9: While busy, the start and status inputs are ignored. The output sequence and its timing are unchanged.
- R10: done is never high for two cycles in a row, skipped is high only together with done, and busy is low whenever done is high.
- R11: A start after a completed sequence begins again from the R3 write when status is low. When status is high it is skipped and the final output values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| hs_sts_i | input | 1 | Cache head-switch powered status |
| l2_ctl_o | output | 32 | Cache power control word |
| dbg_ovr_o | output | 1 | Debug-preset override |
| clk_br_o | output | 2 | Clock branch word: bit 0 enable, bit 1 hardware control |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| skipped_o | output | 1 | With done: the sequence was skipped |

## Verification
The bench builds the block with CYC_PER_US set to 3. Each short wait then lasts 6 cycles and the long wait 162 cycles, so a complete power-up takes under 200 cycles. This lets the bench sample every cycle of every stage and confirm each hold length exactly, rather than only spot-checking the ends of the waits. With the default count a single sequence would run past a thousand cycles. The small value keeps the skip path, the ignored mid-run inputs and a full restart within one short run.

// File: rtl/l2pu_pkg.sv
package l2pu_pkg;

    // control word bit positions (decoded by the power switch logic)
    localparam int L2C_ARR_HS    = 0;
    localparam int L2C_SCU_HS    = 1;
    localparam int L2C_HS_CLAMP  = 8;
    localparam int L2C_HS_EN     = 9;
    localparam int L2C_HS_RST    = 10;
    localparam int L2C_SYS_RST   = 12;
    localparam int L2C_SCU_CLAMP = 14;
    localparam int L2C_ARR_CLAMP = 15;
    localparam int L2C_CNT_LSB   = 16;
    localparam int L2C_CNT_W     = 8;
    localparam int L2C_PWR_ON    = 28;

    // clock branch word bit positions
    localparam int CKB_EN    = 0;
    localparam int CKB_HWCTL = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_A,
        ST_ARRAY_ON,
        ST_WAIT_B,
        ST_HS_UNCLAMP,
        ST_WAIT_C,
        ST_RST_REL,
        ST_WAIT_D,
        ST_HW_CTL
    } seq_st_e;

    typedef struct packed {
        seq_st_e     state;
        logic [31:0] ctl;
        logic        ovr;
        logic [1:0]  ckb;
        logic        done;
        logic        skipped;
    } seq_reg_t;

    function automatic logic [31:0] first_word(input int hs_cnt);
        logic [31:0] w;
        w = '0;
        w[L2C_HS_CLAMP]  = 1'b1;
        w[L2C_HS_EN]     = 1'b1;
        w[L2C_HS_RST]    = 1'b1;
        w[L2C_SYS_RST]   = 1'b1;
        w[L2C_SCU_CLAMP] = 1'b1;
        w[L2C_ARR_CLAMP] = 1'b1;
        w[L2C_CNT_LSB +: L2C_CNT_W] = L2C_CNT_W'(hs_cnt);
        return w;
    endfunction

endpackage

// File: rtl/l2pu_timer.sv
module l2pu_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/l2pu_fsm.sv
module l2pu_fsm
    import l2pu_pkg::*;
#(
    parameter int TW       = 8,
    parameter int SHORT_LD = 1,
    parameter int LONG_LD  = 1,
    parameter int HS_CNT   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hs_sts_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic [31:0]   l2_ctl_o,
    output logic          dbg_ovr_o,
    output logic [1:0]    clk_br_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          skipped_o
);

    localparam logic [TW-1:0] SHORT_VAL = TW'(SHORT_LD);
    localparam logic [TW-1:0] LONG_VAL  = TW'(LONG_LD);
    localparam logic [31:0]   INIT_WORD = first_word(HS_CNT);

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.skipped = 1'b0;
        tmr_load_o  = 1'b0;
        tmr_val_o   = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (hs_sts_i) begin
                        r_d.done    = 1'b1;
                        r_d.skipped = 1'b1;
                    end else begin
                        r_d.ctl   = INIT_WORD;
                        r_d.ovr   = 1'b1;
                        r_d.ckb   = '0;
                        r_d.state = ST_WAIT_A;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = SHORT_VAL;
                    end
                end
            end
            ST_WAIT_A: begin
                if (tmr_zero_i) begin
                    r_d.ctl[L2C_SCU_CLAMP] = 1'b0;
                    r_d.ctl[L2C_ARR_CLAMP] = 1'b0;
                    r_d.state = ST_ARRAY_ON;
                end
            end
            ST_ARRAY_ON: begin
                r_d.ctl[L2C_ARR_HS] = 1'b1;
                r_d.ctl[L2C_SCU_HS] = 1'b1;
                r_d.state  = ST_WAIT_B;
                tmr_load_o = 1'b1;
                tmr_val_o  = SHORT_VAL;
            end
            ST_WAIT_B: begin
                if (tmr_zero_i) begin
                    r_d.ckb[CKB_EN] = 1'b1;
                    r_d.state = ST_HS_UNCLAMP;
                end
            end
            ST_HS_UNCLAMP: begin
                r_d.ctl[L2C_HS_CLAMP] = 1'b0;
                r_d.state  = ST_WAIT_C;
                tmr_load_o = 1'b1;
                tmr_val_o  = SHORT_VAL;
            end
            ST_WAIT_C: begin
                if (tmr_zero_i) begin
                    r_d.ovr   = 1'b0;
                    r_d.state = ST_RST_REL;
                end
            end
            ST_RST_REL: begin
                r_d.ctl[L2C_HS_RST]  = 1'b0;
                r_d.ctl[L2C_SYS_RST] = 1'b0;
                r_d.state  = ST_WAIT_D;
                tmr_load_o = 1'b1;
                tmr_val_o  = LONG_VAL;
            end
            ST_WAIT_D: begin
                if (tmr_zero_i) begin
                    r_d.ctl[L2C_PWR_ON] = 1'b1;
                    r_d.state = ST_HW_CTL;
                end
            end
            ST_HW_CTL: begin
                r_d.ckb[CKB_HWCTL] = 1'b1;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.ctl     <= '0;
            r_q.ovr     <= 1'b0;
            r_q.ckb     <= '0;
            r_q.done    <= 1'b0;
            r_q.skipped <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign l2_ctl_o  = r_q.ctl;
    assign dbg_ovr_o = r_q.ovr;
    assign clk_br_o  = r_q.ckb;
    assign busy_o    = (r_q.state != ST_IDLE);
    assign done_o    = r_q.done;
    assign skipped_o = r_q.skipped;

endmodule

// File: rtl/l2_pwrup_seq.sv
module l2_pwrup_seq #(
    parameter int CYC_PER_US = 20,
    parameter int SHORT_US   = 2,
    parameter int LONG_US    = 54,
    parameter int HS_CNT     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        hs_sts_i,
    output logic [31:0] l2_ctl_o,
    output logic        dbg_ovr_o,
    output logic [1:0]  clk_br_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        skipped_o
);

    localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
    localparam int LONG_CYC  = LONG_US * CYC_PER_US;
    localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int TW        = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    l2pu_timer #(
        .W (TW)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    l2pu_fsm #(
        .TW       (TW),
        .SHORT_LD (SHORT_CYC - 1),
        .LONG_LD  (LONG_CYC - 1),
        .HS_CNT   (HS_CNT)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .hs_sts_i   (hs_sts_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .l2_ctl_o   (l2_ctl_o),
        .dbg_ovr_o  (dbg_ovr_o),
        .clk_br_o   (clk_br_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .skipped_o  (skipped_o)
    );

endmodule

// File: rtl/l2pu_checker.sv
module l2pu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] l2_ctl_o,
    input logic        dbg_ovr_o,
    input logic [1:0]  clk_br_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        skipped_o
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_SKIP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        skipped_o |-> done_o); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10

    AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        skipped_o |-> ($stable(l2_ctl_o) && $stable(dbg_ovr_o) && $stable(clk_br_o))); // R2

    AST_PWR_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l2_ctl_o[28]) |-> (!l2_ctl_o[10] && !l2_ctl_o[12] && !dbg_ovr_o)); // R7

    AST_HWCTL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_br_o[1]) |-> (l2_ctl_o[28] && done_o && !skipped_o)); // R7

    AST_UNCLAMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_ctl_o[9] && !l2_ctl_o[8]) |-> (l2_ctl_o[1:0] == 2'b11 && !l2_ctl_o[14] && !l2_ctl_o[15] && clk_br_o[0])); // R5

    AST_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !l2_ctl_o[11]); // R8

endmodule

bind l2_pwrup_seq l2pu_checker i_l2pu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .l2_ctl_o  (l2_ctl_o),
    .dbg_ovr_o (dbg_ovr_o),
    .clk_br_o  (clk_br_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .skipped_o (skipped_o)
);

// File: tb/test_l2_pwrup_seq.sv
module test_l2_pwrup_seq;

    localparam int CPU   = 3;
    localparam int SHORT = 2 * CPU;
    localparam int LONG  = 54 * CPU;

    typedef struct packed {
        logic [31:0] ctl;
        logic        ovr;
        logic [1:0]  ckb;
        logic        done;
        logic        busy;
        logic [15:0] hold;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'h0010D700, 1'b1, 2'b00, 1'b0, 1'b1, 16'(SHORT)},
        '{32'h00101700, 1'b1, 2'b00, 1'b0, 1'b1, 16'd1},
        '{32'h00101703, 1'b1, 2'b00, 1'b0, 1'b1, 16'(SHORT)},
        '{32'h00101703, 1'b1, 2'b01, 1'b0, 1'b1, 16'd1},
        '{32'h00101603, 1'b1, 2'b01, 1'b0, 1'b1, 16'(SHORT)},
        '{32'h00101603, 1'b0, 2'b01, 1'b0, 1'b1, 16'd1},
        '{32'h00100203, 1'b0, 2'b01, 1'b0, 1'b1, 16'(LONG)},
        '{32'h10100203, 1'b0, 2'b01, 1'b0, 1'b1, 16'd1},
        '{32'h10100203, 1'b0, 2'b11, 1'b1, 1'b0, 16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        hs_sts_i = 1'b0;
    logic [31:0] l2_ctl_o;
    logic        dbg_ovr_o;
    logic [1:0]  clk_br_o;
    logic        busy_o;
    logic        done_o;
    logic        skipped_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    l2_pwrup_seq #(
        .CYC_PER_US (CPU)
    ) i_l2_pwrup_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .hs_sts_i  (hs_sts_i),
        .l2_ctl_o  (l2_ctl_o),
        .dbg_ovr_o (dbg_ovr_o),
        .clk_br_o  (clk_br_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .skipped_o (skipped_o)
    );

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R3/R8";
            1, 2:    return "R4/R8";
            3, 4:    return "R5/R8";
            5, 6:    return "R6/R8";
            default: return "R7/R8";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] ctl_e, input logic ovr_e,
                       input logic [1:0] ckb_e, input logic done_e, input logic skip_e,
                       input logic busy_e);
        logic [37:0] act, exp;
        act = {l2_ctl_o, dbg_ovr_o, clk_br_o, done_o, skipped_o, busy_o};
        exp = {ctl_e, ovr_e, ckb_e, done_e, skip_e, busy_e};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual ctl=%h ovr=%b ckb=%b done=%b skip=%b busy=%b expected ctl=%h ovr=%b ckb=%b done=%b skip=%b busy=%b",
                     req, $time, l2_ctl_o, dbg_ovr_o, clk_br_o, done_o, skipped_o, busy_o,
                     ctl_e, ovr_e, ckb_e, done_e, skip_e, busy_e);
        end
    endtask

    // walks the vector table; poke=1 drives start and status mid-run (R9)
    task automatic run_seq(input bit poke);
        hs_sts_i = 1'b0;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 9; i++) begin
            for (int h = 0; h < int'(VECS[i].hold); h++) begin
                chk(poke ? "R9" : tag_of(i), VECS[i].ctl, VECS[i].ovr, VECS[i].ckb,
                    VECS[i].done, 1'b0, VECS[i].busy);
                if (poke && i == 2 && h == 0) begin
                    start_i  = 1'b1;
                    hs_sts_i = 1'b1;
                end
                if (poke && i == 2 && h == 1) begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
        end
        hs_sts_i = 1'b0;
        chk("R10", 32'h10100203, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);

        // skip from reset state
        hs_sts_i = 1'b1;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        hs_sts_i = 1'b0;
        chk("R2", 32'h0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R10", 32'h0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);

        // full sequence, inputs poked while busy
        run_seq(1'b1);

        // skip after completion keeps final values
        hs_sts_i = 1'b1;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        hs_sts_i = 1'b0;
        chk("R11", 32'h10100203, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R2", 32'h10100203, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0);

        // restart from the first write, clean run
        run_seq(1'b0);

        // idle with no start: nothing moves
        repeat (5) @(negedge clk);
        chk("R11", 32'h10100203, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule